// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the signals of an incremental shaft encoder into position information. It takes two phase inputs, a once-per-turn index pulse and a home switch. It produces a phase counter that runs within one revolution, a revolution counter that counts whole turns, a free-running timer, the current rotation direction and the synchronised levels of the two phase inputs. A 2-bit mode input selects how the phase inputs are read: as a quadrature pair, as a step pulse plus a direction level, or as separate up and down pulses.

The phase counter wraps at a programmable maximum. It can be reloaded with a programmable index value when the index pulse arrives. The revolution counter follows either the phase-counter wraps or the index pulse, whichever the configuration selects. Control inputs clear the counters, reset them while the home switch is asserted, and freeze them while a pause input is high. A home pulse is raised on a selectable combination of home-switch edge and rotation direction.

All four encoder pins pass through a two-stage synchroniser and then an edge-detect register. A pin change becomes visible on the counter outputs three clock edges after it is first sampled.

Top module: `qenc_position`

## Requirements
- R1: After reset, all counters, `dir`, `home_pulse` and `z_pulse` are 0. `a_lvl` and `b_lvl` show `enc_a` and `enc_b` two clock edges after these inputs change.
- R2: With `mode`=00, the phase-state order (A,B) = 00, 10, 11, 01, 00 counts up by one per transition, and the reverse order counts down by one. A jump of both bits at once does not count and leaves `dir` unchanged. `dir` becomes 0 after an up count and 1 after a down count.
- R3: With `mode`=01, each rising edge of A is one count, up when B is low and down when B is high. A falling edge of A and any change of B do not count.
- R4: With `mode`=10, a rising edge of A counts up and a rising edge of B counts down. Rising edges of A and B in the same cycle cancel each other. With `mode`=11, nothing counts.
- R5: When the phase counter counts up from `ph_max` it goes to 0. When it counts down from 0 it goes to `ph_max`.
- R6: With `rev_from_wrap`=1, the revolution counter increments on an up wrap of the phase counter and decrements on a down wrap, in the same cycle as the wrap.
- R7: With `rev_from_wrap`=0, each rising edge of Z increments the revolution counter when `dir` is 0 and decrements it when `dir` is 1.
- R8: With `z_cal_en`=1, a rising edge of Z loads `ph_index` into the phase counter, and this takes priority over a count in the same cycle.
- R9: While `cnt_clear` is high, the revolution counter and the timer go to 0 and the phase counter holds `ph_index`, regardless of count events.
- R10: While the synchronised home input is high, `h_clr_ph` loads `ph_index` into the phase counter and `h_clr_rev` clears the revolution counter.
- R11: While `pause` is high, `pause_ph` freezes the phase counter and `pause_rev` freezes the revolution counter. `dir` still follows the motion.
- R12: `home_mask` selects when `home_pulse` fires: bit 0 on a home rising edge with `dir`=0, bit 1 on a rising edge with `dir`=1, bit 2 on a falling edge with `dir`=0, bit 3 on a falling edge with `dir`=1.
- R13: The timer increments by one every clock when `cnt_clear` is low.
- R14: `z_pulse` is high for exactly one cycle per rising edge of Z, in the cycle in which the counters react to that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_z | input | 1 | Encoder index pulse, asynchronous |
| enc_h | input | 1 | Home switch, asynchronous |
| mode | input | 2 | Decoding: 00 quadrature, 01 pulse/direction, 10 up/down, 11 off |
| ph_max | input | PH_W | Largest phase-counter value |
| ph_index | input | PH_W | Phase-counter load value |
| rev_from_wrap | input | 1 | 1: revolutions follow phase wraps; 0: they follow Z |
| z_cal_en | input | 1 | Load the phase counter on a Z rising edge |
| cnt_clear | input | 1 | Synchronous counter clear |
| h_clr_rev | input | 1 | Clear the revolution counter while home is high |
| h_clr_ph | input | 1 | Load the phase counter while home is high |
| pause | input | 1 | Pause request |
| pause_rev | input | 1 | Pause applies to the revolution counter |
| pause_ph | input | 1 | Pause applies to the phase counter |
| home_mask | input | 4 | Edge/direction selection for the home pulse |
| ph_cnt | output | PH_W | Phase counter |
| rev_cnt | output | REV_W | Revolution counter |
| tmr_cnt | output | TMR_W | Free-running timer |
| dir | output | 1 | 1 reverse, 0 forward |
| a_lvl | output | 1 | Synchronised A level |
| b_lvl | output | 1 | Synchronised B level |
| home_pulse | output | 1 | One-cycle home event |
| z_pulse | output | 1 | One-cycle Z event |

## Verification
The bench builds the block with PH_W=6, REV_W=8 and TMR_W=16. With these sizes, complete up and down sweeps through the phase range reach every wrap. The sweeps run for maximum values of 1, 2, 5 and 63, the last being the full 6-bit range. The revolution counter crosses both wrap directions within a few hundred steps. The small widths also make it practical to walk all sixteen combinations of home-mask bit, direction and edge.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    ENC_QUAD      = 2'b00,
    ENC_PULSE_DIR = 2'b01,
    ENC_UP_DOWN   = 2'b10,
    ENC_OFF       = 2'b11
  } enc_mode_e;

  // Bit positions of the encoder pins inside the synchroniser vector
  localparam int PIN_A = 0;
  localparam int PIN_B = 1;
  localparam int PIN_Z = 2;
  localparam int PIN_H = 3;
  localparam int PIN_N = 4;

  // Position of an (A,B) pair on the quadrature circle: 00->0, 10->1, 11->2, 01->3
  function automatic logic [1:0] quad_pos(input logic a, input logic b);
    return {b, a ^ b};
  endfunction

  // Circle distance between two phase states: 1 forward, 3 reverse, 0/2 no count
  function automatic logic [1:0] quad_delta(input logic pa, input logic pb,
                                            input logic ca, input logic cb);
    logic [1:0] d;
    d = quad_pos(ca, cb) - quad_pos(pa, pb);
    return d;
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);

  logic [N-1:0] stg_q [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign cur  = stg_q[STAGES-1];
  assign prev = prev_q;

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       a_cur,
  input  logic       a_prev,
  input  logic       b_cur,
  input  logic       b_prev,
  output logic       step_up,
  output logic       step_dn,
  output logic       dir
);

  logic       a_rise;
  logic       b_rise;
  logic [1:0] qd;
  logic       dir_q;

  assign a_rise = a_cur & ~a_prev;
  assign b_rise = b_cur & ~b_prev;
  assign qd     = quad_delta(a_prev, b_prev, a_cur, b_cur);

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    case (enc_mode_e'(mode))
      ENC_QUAD: begin
        step_up = (qd == 2'd1);
        step_dn = (qd == 2'd3);
      end
      ENC_PULSE_DIR: begin
        step_up = a_rise & ~b_cur;
        step_dn = a_rise &  b_cur;
      end
      ENC_UP_DOWN: begin
        step_up = a_rise & ~b_rise;
        step_dn = b_rise & ~a_rise;
      end
      default: begin
        step_up = 1'b0;
        step_dn = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dir_q <= 1'b0;
    else if (step_dn) dir_q <= 1'b1;
    else if (step_up) dir_q <= 1'b0;
  end

  assign dir = dir_q;

  // R2: direction tracks the most recent count
  assert_dir_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> !dir);
  assert_dir_rev_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |=> dir);
  // R4: at most one count per cycle
  assert_one_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));

endmodule

// File: rtl/qenc_counters.sv
module qenc_counters #(
  parameter int PH_W  = 21,
  parameter int REV_W = 32,
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             z_rise,
  input  logic             h_lvl,
  input  logic             dir,
  input  logic [PH_W-1:0]  ph_max,
  input  logic [PH_W-1:0]  ph_index,
  input  logic             rev_from_wrap,
  input  logic             z_cal_en,
  input  logic             cnt_clear,
  input  logic             h_clr_rev,
  input  logic             h_clr_ph,
  input  logic             pause,
  input  logic             pause_rev,
  input  logic             pause_ph,
  output logic [PH_W-1:0]  ph_cnt,
  output logic [REV_W-1:0] rev_cnt,
  output logic [TMR_W-1:0] tmr_cnt
);

  function automatic logic [PH_W-1:0] ph_advance(input logic [PH_W-1:0] cur,
                                                 input logic [PH_W-1:0] top,
                                                 input logic            up);
    if (up) return (cur == top) ? '0 : cur + 1'b1;
    else    return (cur == '0)  ? top : cur - 1'b1;
  endfunction

  function automatic logic [REV_W-1:0] rev_advance(input logic [REV_W-1:0] cur,
                                                   input logic inc,
                                                   input logic dec);
    if (inc)      return cur + 1'b1;
    else if (dec) return cur - 1'b1;
    else          return cur;
  endfunction

  logic ph_reset, ph_hold, ph_live, ph_cal, ph_up, ph_dn;
  logic wrap_up, wrap_dn;
  logic rev_reset, rev_hold, rev_inc, rev_dec;
  logic [PH_W-1:0]  ph_q;
  logic [REV_W-1:0] rev_q;
  logic [TMR_W-1:0] tmr_q;

  assign ph_reset = cnt_clear | (h_clr_ph & h_lvl);
  assign ph_hold  = pause & pause_ph;
  assign ph_live  = ~ph_reset & ~ph_hold;
  assign ph_cal   = ph_live & z_cal_en & z_rise;
  assign ph_up    = ph_live & ~ph_cal & step_up;
  assign ph_dn    = ph_live & ~ph_cal & step_dn;
  assign wrap_up  = ph_up & (ph_q == ph_max);
  assign wrap_dn  = ph_dn & (ph_q == '0);

  assign rev_reset = cnt_clear | (h_clr_rev & h_lvl);
  assign rev_hold  = pause & pause_rev;
  assign rev_inc   = rev_from_wrap ? wrap_up : (z_rise & ~dir);
  assign rev_dec   = rev_from_wrap ? wrap_dn : (z_rise &  dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ph_q <= '0;
    else if (ph_reset)       ph_q <= ph_index;
    else if (ph_hold)        ph_q <= ph_q;
    else if (ph_cal)         ph_q <= ph_index;
    else if (ph_up || ph_dn) ph_q <= ph_advance(ph_q, ph_max, ph_up);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rev_q <= '0;
    else if (rev_reset) rev_q <= '0;
    else if (!rev_hold) rev_q <= rev_advance(rev_q, rev_inc, rev_dec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tmr_q <= '0;
    else if (cnt_clear) tmr_q <= '0;
    else                tmr_q <= tmr_q + 1'b1;
  end

  assign ph_cnt  = ph_q;
  assign rev_cnt = rev_q;
  assign tmr_cnt = tmr_q;

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (rev_cnt == '0 && tmr_cnt == '0 && ph_cnt == $past(ph_index)));
  assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_up |=> ph_cnt == '0);
  assert_wrap_dn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_dn |=> ph_cnt == $past(ph_max));
  assert_rev_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_from_wrap && wrap_up && !rev_reset && !rev_hold) |=> rev_cnt == $past(rev_cnt) + 1'b1);
  assert_cal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ph_cal |=> ph_cnt == $past(ph_index));
  assert_pause_ph_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && pause_ph && !ph_reset) |=> $stable(ph_cnt));
  assert_pause_rev_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && pause_rev && !rev_reset) |=> $stable(rev_cnt));
  assert_tmr_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> tmr_cnt == $past(tmr_cnt) + 1'b1);

endmodule

// File: rtl/qenc_events.sv
module qenc_events (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       h_cur,
  input  logic       h_prev,
  input  logic       z_rise,
  input  logic       dir,
  input  logic [3:0] home_mask,
  output logic       home_pulse,
  output logic       z_pulse
);

  logic h_rise, h_fall, home_hit;
  logic home_q, z_q;

  assign h_rise   = h_cur & ~h_prev;
  assign h_fall   = ~h_cur & h_prev;
  // mask index = {falling edge, direction}
  assign home_hit = (h_rise & home_mask[{1'b0, dir}]) |
                    (h_fall & home_mask[{1'b1, dir}]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      home_q <= 1'b0;
      z_q    <= 1'b0;
    end else begin
      home_q <= home_hit;
      z_q    <= z_rise;
    end
  end

  assign home_pulse = home_q;
  assign z_pulse    = z_q;

  assert_home_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
    home_pulse |-> $past(h_cur != h_prev));
  assert_zpulse_single_R14: assert property (@(posedge clk) disable iff (!rst_n)
    z_pulse |=> !z_pulse);

endmodule

// File: rtl/qenc_position.sv
module qenc_position
  import qenc_pkg::*;
#(
  parameter int PH_W  = 21,
  parameter int REV_W = 32,
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_z,
  input  logic             enc_h,
  input  logic [1:0]       mode,
  input  logic [PH_W-1:0]  ph_max,
  input  logic [PH_W-1:0]  ph_index,
  input  logic             rev_from_wrap,
  input  logic             z_cal_en,
  input  logic             cnt_clear,
  input  logic             h_clr_rev,
  input  logic             h_clr_ph,
  input  logic             pause,
  input  logic             pause_rev,
  input  logic             pause_ph,
  input  logic [3:0]       home_mask,
  output logic [PH_W-1:0]  ph_cnt,
  output logic [REV_W-1:0] rev_cnt,
  output logic [TMR_W-1:0] tmr_cnt,
  output logic             dir,
  output logic             a_lvl,
  output logic             b_lvl,
  output logic             home_pulse,
  output logic             z_pulse
);

  logic [PIN_N-1:0] pin_raw, pin_cur, pin_prev;
  logic step_up, step_dn, z_rise, dir_w;

  assign pin_raw[PIN_A] = enc_a;
  assign pin_raw[PIN_B] = enc_b;
  assign pin_raw[PIN_Z] = enc_z;
  assign pin_raw[PIN_H] = enc_h;

  qenc_sync #(.N(PIN_N), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_raw), .cur(pin_cur), .prev(pin_prev)
  );

  assign z_rise = pin_cur[PIN_Z] & ~pin_prev[PIN_Z];

  qenc_decode u_decode (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .a_cur(pin_cur[PIN_A]), .a_prev(pin_prev[PIN_A]),
    .b_cur(pin_cur[PIN_B]), .b_prev(pin_prev[PIN_B]),
    .step_up(step_up), .step_dn(step_dn), .dir(dir_w)
  );

  qenc_counters #(.PH_W(PH_W), .REV_W(REV_W), .TMR_W(TMR_W)) u_counters (
    .clk(clk), .rst_n(rst_n),
    .step_up(step_up), .step_dn(step_dn), .z_rise(z_rise),
    .h_lvl(pin_cur[PIN_H]), .dir(dir_w),
    .ph_max(ph_max), .ph_index(ph_index),
    .rev_from_wrap(rev_from_wrap), .z_cal_en(z_cal_en), .cnt_clear(cnt_clear),
    .h_clr_rev(h_clr_rev), .h_clr_ph(h_clr_ph),
    .pause(pause), .pause_rev(pause_rev), .pause_ph(pause_ph),
    .ph_cnt(ph_cnt), .rev_cnt(rev_cnt), .tmr_cnt(tmr_cnt)
  );

  qenc_events u_events (
    .clk(clk), .rst_n(rst_n),
    .h_cur(pin_cur[PIN_H]), .h_prev(pin_prev[PIN_H]),
    .z_rise(z_rise), .dir(dir_w), .home_mask(home_mask),
    .home_pulse(home_pulse), .z_pulse(z_pulse)
  );

  assign dir   = dir_w;
  assign a_lvl = pin_cur[PIN_A];
  assign b_lvl = pin_cur[PIN_B];

  // R7: Z-driven revolution step follows the direction
  assert_zrev_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (z_rise && !rev_from_wrap && !cnt_clear && !(h_clr_rev && pin_cur[PIN_H]) &&
     !(pause && pause_rev)) |=> rev_cnt != $past(rev_cnt));
  // R1: synchronised levels never change without a raw change before
  assert_alvl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(enc_a) |=> ##1 (a_lvl == $past(enc_a, 2)));

endmodule

// File: tb/qenc_position_tb.sv
module qenc_position_tb;

  localparam int PH_W  = 6;
  localparam int REV_W = 8;
  localparam int TMR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 0, enc_b = 0, enc_z = 0, enc_h = 0;
  logic [1:0] mode = 2'b00;
  logic [PH_W-1:0] ph_max = '1, ph_index = '0;
  logic rev_from_wrap = 1, z_cal_en = 0, cnt_clear = 0;
  logic h_clr_rev = 0, h_clr_ph = 0, pause = 0, pause_rev = 0, pause_ph = 0;
  logic [3:0] home_mask = 4'b0;
  logic [PH_W-1:0]  ph_cnt;
  logic [REV_W-1:0] rev_cnt;
  logic [TMR_W-1:0] tmr_cnt;
  logic dir, a_lvl, b_lvl, home_pulse, z_pulse;

  always #4 clk = ~clk;

  qenc_position #(.PH_W(PH_W), .REV_W(REV_W), .TMR_W(TMR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z), .enc_h(enc_h),
    .mode(mode), .ph_max(ph_max), .ph_index(ph_index), .rev_from_wrap(rev_from_wrap),
    .z_cal_en(z_cal_en), .cnt_clear(cnt_clear), .h_clr_rev(h_clr_rev), .h_clr_ph(h_clr_ph),
    .pause(pause), .pause_rev(pause_rev), .pause_ph(pause_ph), .home_mask(home_mask),
    .ph_cnt(ph_cnt), .rev_cnt(rev_cnt), .tmr_cnt(tmr_cnt), .dir(dir),
    .a_lvl(a_lvl), .b_lvl(b_lvl), .home_pulse(home_pulse), .z_pulse(z_pulse)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int exp_ph = 0;
  logic [REV_W-1:0] exp_rev = '0;
  int exp_dir = 0;
  logic [1:0] qpos = 2'd0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // three edges take a pin change through sync, sync and edge-detect to the counters
  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_pos(input logic [1:0] p);
    qpos  = p;
    enc_a = (p == 2'd1) || (p == 2'd2);
    enc_b = (p == 2'd2) || (p == 2'd3);
  endtask

  task automatic model_step(input bit up);
    int top = int'(ph_max);
    if (up) begin
      exp_dir = 0;
      if (exp_ph == top) begin exp_ph = 0; if (rev_from_wrap) exp_rev = exp_rev + 1'b1; end
      else exp_ph = exp_ph + 1;
    end else begin
      exp_dir = 1;
      if (exp_ph == 0) begin exp_ph = top; if (rev_from_wrap) exp_rev = exp_rev - 1'b1; end
      else exp_ph = exp_ph - 1;
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " ph"},  int'(ph_cnt),  exp_ph);
    chk({tag, " rev"}, int'(rev_cnt), int'(exp_rev));
    chk({tag, " dir"}, int'(dir),     exp_dir);
  endtask

  task automatic quad_move(input bit up);
    drive_pos(up ? qpos + 2'd1 : qpos - 2'd1);
    settle();
    model_step(up);
    check_state("R2/R5/R6 quad");
    chk("R1 a_lvl", int'(a_lvl), int'(enc_a));
    chk("R1 b_lvl", int'(b_lvl), int'(enc_b));
  endtask

  task automatic clear_pulse();
    cnt_clear = 1;
    @(negedge clk);
    cnt_clear = 0;
    exp_ph = int'(ph_index);
    exp_rev = '0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 reset ph", int'(ph_cnt), 0);
    chk("R1 reset rev", int'(rev_cnt), 0);
    chk("R1 reset dir", int'(dir), 0);
    chk("R1 reset home", int'(home_pulse), 0);
    chk("R1 reset z", int'(z_pulse), 0);

    // R2 R5 R6: full sweeps for several maxima
    for (int mi = 0; mi < 4; mi++) begin
      ph_max = (mi == 0) ? 6'd1 : (mi == 1) ? 6'd2 : (mi == 2) ? 6'd5 : 6'd63;
      ph_index = '0;
      clear_pulse();
      for (int s = 0; s < 2 * int'(ph_max) + 3; s++) quad_move(1);
      for (int s = 0; s < 2 * int'(ph_max) + 3; s++) quad_move(0);
    end
    ph_max = 6'd7;
    clear_pulse();
    quad_move(1);
    quad_move(1);

    // R2: illegal two-bit jump
    drive_pos(qpos + 2'd2);
    settle();
    check_state("R2 jump");

    // R3: pulse/direction
    mode = 2'b01;
    enc_a = 0; enc_b = 1; settle(); check_state("R3 b change");
    enc_a = 1; settle(); model_step(0); check_state("R3 a rise down");
    enc_a = 0; settle(); check_state("R3 a fall");
    enc_b = 0; settle(); check_state("R3 b fall");
    enc_a = 1; settle(); model_step(1); check_state("R3 a rise up");
    enc_a = 0; settle();

    // R4: up/down and off modes
    mode = 2'b10;
    enc_a = 1; settle(); model_step(1); check_state("R4 a rise");
    enc_a = 0; settle(); check_state("R4 a fall");
    enc_b = 1; settle(); model_step(0); check_state("R4 b rise");
    enc_b = 0; settle(); check_state("R4 b fall");
    enc_a = 1; enc_b = 1; settle(); check_state("R4 both rise");
    enc_a = 0; enc_b = 0; settle();
    mode = 2'b11;
    enc_a = 1; settle(); check_state("R4 off mode");
    enc_a = 0; settle();
    mode = 2'b00; qpos = 2'd0;

    // R7 R14: revolutions from Z
    rev_from_wrap = 0;
    quad_move(1);
    enc_z = 1; settle(); exp_rev = exp_rev + 1'b1; check_state("R7 z fwd");
    chk("R14 z pulse on", int'(z_pulse), 1);
    @(negedge clk); chk("R14 z pulse off", int'(z_pulse), 0);
    enc_z = 0; settle();
    quad_move(0);
    enc_z = 1; settle(); exp_rev = exp_rev - 1'b1; check_state("R7 z rev");
    enc_z = 0; settle();

    // R8: Z calibration
    z_cal_en = 1; ph_index = 6'd5;
    enc_z = 1; settle(); exp_ph = 5; exp_rev = exp_rev - 1'b1; check_state("R8 cal");
    enc_z = 0; settle(); z_cal_en = 0;

    // R9 R13: clear priority and timer
    ph_index = 6'd3;
    cnt_clear = 1;
    drive_pos(qpos + 2'd1); settle();
    exp_ph = 3; exp_rev = '0; exp_dir = 0;
    check_state("R9 clear wins");
    chk("R9 tmr held", int'(tmr_cnt), 0);
    cnt_clear = 0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R13 tmr", int'(tmr_cnt), 10);

    // R10: home resets
    quad_move(1); quad_move(1);
    enc_z = 1; settle(); exp_rev = exp_rev + 1'b1; enc_z = 0; settle();
    h_clr_ph = 1; ph_index = 6'd2;
    enc_h = 1; settle(); exp_ph = 2; check_state("R10 home ph");
    h_clr_ph = 0; h_clr_rev = 1;
    @(posedge clk); @(negedge clk); exp_rev = '0; check_state("R10 home rev");
    h_clr_rev = 0; enc_h = 0; settle();

    // R11: pause
    pause = 1; pause_ph = 1;
    drive_pos(qpos + 2'd1); settle(); exp_dir = 0; check_state("R11 ph frozen");
    pause_ph = 0; pause_rev = 1;
    enc_z = 1; settle(); check_state("R11 rev frozen");
    enc_z = 0; settle();
    quad_move(1);
    pause = 0; pause_rev = 0;

    // R12: home edge/direction matrix
    for (int d = 0; d < 2; d++) begin
      quad_move(d == 0);
      for (int bi = 0; bi < 4; bi++) begin
        home_mask = 4'(1 << bi);
        enc_h = 1; settle();
        chk($sformatf("R12 rise dir%0d bit%0d", d, bi), int'(home_pulse), int'(bi == d));
        enc_h = 0; settle();
        chk($sformatf("R12 fall dir%0d bit%0d", d, bi), int'(home_pulse), int'(bi == 2 + d));
      end
    end

    done = 1;
    report();
  end

endmodule